// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and takes a bank of memory rows from power-up to normal operation. After a start pulse it waits for supplies and clocks to settle, then walks a fixed list of commands: a no-operation, a precharge of all banks, a programmable number of auto (CBR) refreshes and a mode-register set. Each command is followed by a programmable wait. When the list is finished it drives the normal-operation code for one cycle, raises `done` and starts a periodic refresh timer.

Each command step visits the rows one per cycle in ascending index order. A row is selected only if it holds memory. This is judged from the cumulative row boundary inputs: a row whose boundary is greater than the boundary of the row below it is populated. Unpopulated rows get a NOP with no select in their slot. For the mode-register set, the address on the command port depends on the row group and on the CAS latency. All wait lengths are parameters counted in controller clocks.

Top module: `sdram_init_seq`

## Requirements
- R1: Command codes on `cmd_code` are 000 normal, 001 NOP, 010 precharge all, 011 mode-register set, 100 CBR refresh. After start, the step order is: settle, NOP, precharge, `N_CBR` CBR steps, mode-register set, then one cycle of normal, then done.
- R2: The sequence has fixed timing. Start is sampled at clock edge 0. The settle phase lasts `T_PWR` cycles. Each command step takes `NROWS` cycles, in which row i is served in the i-th cycle. After each step comes its wait: `T_NOP` after NOP, `T_RP` after precharge, `T_RC` after every CBR, and `T_MRD` after the mode-register set.
- R3: Row i (0 to 7) is issued a command only when its 8-bit boundary (bits 8i+7:8i of `row_bound`) is greater than the boundary of row i-1. Row -1 counts as 0. In the slot of a skipped row, the port shows NOP with no select.
- R4: `cmd_cs` is one-hot while a command goes to a row, and bit i selects row i. Otherwise it is zero.
- R5: During a mode-register set, `cmd_addr` is 0x1D0 for rows 0 to 3 and 0x1E28 for rows 4 to 7 when `cas_lat2` is 0. When `cas_lat2` is 1, the values are 0x150 and 0x1EA8. For all other commands `cmd_addr` is zero.
- R6: The normal code is never sent to a row. It appears with `cmd_cs` zero when idle, in the final step and while done.
- R7: During the settle phase and every wait, the port shows NOP with `cmd_cs` zero.
- R8: A start pulse while `busy` is high has no effect on the command trace.
- R9: `done` rises the cycle after the final normal step and stays high until a new start. A start while done restarts the whole sequence.
- R10: Refresh is requested only while done. The rate codes and their intervals in clocks are: 010 gives `REF_UNIT` (7.8 us), 001 gives 2x (15.6 us), 011 gives 4x (31.2 us), 100 gives 8x (62.4 us) and 101 gives 16x (124.8 us). `refresh_req` is a one-cycle pulse at the end of each interval.
- R11: Codes 000, 110 and 111 disable refresh. A change of `rate_code` restarts the interval, so the first pulse comes one full new interval after the clock edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when idle or done |
| row_bound | input | NROWS*BW | Cumulative row boundaries, row i in bits [BW*i +: BW] |
| cas_lat2 | input | 1 | 1 selects CAS latency 2, 0 selects 3 |
| rate_code | input | 3 | Refresh interval code |
| cmd_code | output | 3 | Command to the SDRAM command port |
| cmd_cs | output | NROWS | Row select vector, active high |
| cmd_addr | output | 14 | Mode-register address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, refresh running |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The command trace is checked cycle by cycle against an independent schedule, for several boundary patterns:
- All rows filled.
- Alternating and runs of empty rows.
- No rows filled, so only NOP and waits appear.
- Only the top row filled.
- One row in each group.

Together these separate skip decisions based on equal boundaries from decisions based on a zero boundary. The CAS-latency input is varied across the patterns, which tells apart the four mode-register addresses. A repeated start in mid-sequence must leave the trace unchanged. The refresh timer is measured for every interval code, for both disabling codes, and for a code change in mid-interval.

// File: rtl/sdinit_pkg.sv
// Shared types and constants for the SDRAM initialization sequencer.
// Assumes a 14-bit mode-register address and a 3-bit command field.
package sdinit_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'b000,
        CMD_NOP       = 3'b001,
        CMD_PRECHARGE = 3'b010,
        CMD_MODESET   = 3'b011,
        CMD_REFRESH   = 3'b100
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_ISSUE,
        PH_WAIT,
        PH_FINAL,
        PH_DONE
    } phase_e;

    localparam int MA_W = 14;

    localparam logic [MA_W-1:0] MR_LO_CL3 = 14'h01D0;
    localparam logic [MA_W-1:0] MR_HI_CL3 = 14'h1E28;
    localparam logic [MA_W-1:0] MR_LO_CL2 = 14'h0150;
    localparam logic [MA_W-1:0] MR_HI_CL2 = 14'h1EA8;

endpackage

// File: rtl/sdinit_row_mask.sv
// Marks each row populated when its cumulative boundary exceeds the boundary
// of the row below it (row 0 is compared with zero). Purely combinational.
module sdinit_row_mask #(
    parameter int NROWS = 8,
    parameter int BW    = 8
) (
    input  logic [NROWS*BW-1:0] bounds,
    output logic [NROWS-1:0]    filled
);

    for (genvar i = 0; i < NROWS; i++) begin : g_row
        if (i == 0) begin : g_first
            // first row is populated when its boundary is non-zero
            assign filled[i] = (bounds[BW-1:0] != '0);
        end else begin : g_rest
            // later rows compare against the previous boundary
            assign filled[i] = (bounds[i*BW +: BW] > bounds[(i-1)*BW +: BW]);
        end
    end

endmodule

// File: rtl/sdinit_refresh_timer.sv
// Periodic refresh request generator. The interval is UNIT clocks scaled by
// the rate code; the count restarts when the code changes or run is low.
// Assumes UNIT >= 2 so every pulse lasts exactly one cycle.
module sdinit_refresh_timer #(
    parameter int UNIT = 780
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate,
    output logic       req
);

    localparam int MAXI = UNIT * 16;
    localparam int CW   = $clog2(MAXI + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    last_rate;
    logic [CW-1:0] intv;
    logic          active;

    // decode the rate code into an interval in clocks
    always_comb begin
        case (rate)
            3'b010:  intv = CW'(UNIT);
            3'b001:  intv = CW'(UNIT * 2);
            3'b011:  intv = CW'(UNIT * 4);
            3'b100:  intv = CW'(UNIT * 8);
            3'b101:  intv = CW'(UNIT * 16);
            default: intv = '0;
        endcase
    end

    assign active = run && (rate == last_rate) && (intv != '0);
    assign req    = active && (cnt == intv - CW'(1));

    // interval counter with restart on code change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            last_rate <= 3'b000;
        end else begin
            last_rate <= rate;
            if (!active || req) cnt <= '0;
            else                cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up sequencer. After start: settle wait, then NOP, precharge,
// N_CBR CBR refreshes and mode-register set, each walked over the rows one
// per cycle and followed by its wait; then one normal cycle and done.
// Assumes NROWS is a power of two and every wait parameter is at least 1.
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int NROWS    = 8,
    parameter int BW       = 8,
    parameter int T_PWR    = 20000,
    parameter int T_NOP    = 20000,
    parameter int T_RP     = 3,
    parameter int T_RC     = 9,
    parameter int T_MRD    = 2,
    parameter int N_CBR    = 8,
    parameter int REF_UNIT = 780
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NROWS*BW-1:0] row_bound,
    input  logic                cas_lat2,
    input  logic [2:0]          rate_code,
    output logic [2:0]          cmd_code,
    output logic [NROWS-1:0]    cmd_cs,
    output logic [13:0]         cmd_addr,
    output logic                busy,
    output logic                done,
    output logic                refresh_req
);

    localparam int RW   = (NROWS > 1) ? $clog2(NROWS) : 1;
    localparam int WMAX = (T_PWR > T_NOP) ? T_PWR : T_NOP;
    localparam int WCW  = $clog2(WMAX + T_RP + T_RC + T_MRD + 1);
    localparam int CCW  = $clog2(N_CBR + 1);

    phase_e          phase;
    sd_cmd_e         step_cmd;
    logic [RW-1:0]   row_idx;
    logic [WCW-1:0]  wait_cnt;
    logic [CCW-1:0]  cbr_cnt;
    logic [NROWS-1:0] filled;
    logic [WCW-1:0]  step_wait;
    logic            row_hit;
    logic            upper;

    sdinit_row_mask #(.NROWS(NROWS), .BW(BW)) u_mask (
        .bounds (row_bound),
        .filled (filled)
    );

    sdinit_refresh_timer #(.UNIT(REF_UNIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_DONE),
        .rate  (rate_code),
        .req   (refresh_req)
    );

    // wait length that follows the current command step
    always_comb begin
        case (step_cmd)
            CMD_NOP:       step_wait = WCW'(T_NOP);
            CMD_PRECHARGE: step_wait = WCW'(T_RP);
            CMD_REFRESH:   step_wait = WCW'(T_RC);
            default:       step_wait = WCW'(T_MRD);
        endcase
    end

    assign row_hit = (phase == PH_ISSUE) && filled[row_idx];
    assign upper   = (int'(row_idx) >= NROWS / 2);

    // command port drive for the current phase
    always_comb begin
        cmd_cs   = '0;
        cmd_addr = '0;
        case (phase)
            PH_SETTLE, PH_WAIT: cmd_code = CMD_NOP;
            PH_ISSUE: begin
                cmd_code = row_hit ? step_cmd : CMD_NOP;
                if (row_hit) cmd_cs = NROWS'(1) << row_idx;
                if (row_hit && step_cmd == CMD_MODESET)
                    cmd_addr = cas_lat2 ? (upper ? MR_HI_CL2 : MR_LO_CL2)
                                        : (upper ? MR_HI_CL3 : MR_LO_CL3);
            end
            default: cmd_code = CMD_NORMAL;
        endcase
    end

    assign busy = (phase != PH_IDLE) && (phase != PH_DONE);
    assign done = (phase == PH_DONE);

    // sequence state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            step_cmd <= CMD_NOP;
            row_idx  <= '0;
            wait_cnt <= '0;
            cbr_cnt  <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        phase    <= PH_SETTLE;
                        wait_cnt <= WCW'(T_PWR - 1);
                    end
                end
                PH_SETTLE: begin
                    if (wait_cnt == '0) begin
                        phase    <= PH_ISSUE;
                        step_cmd <= CMD_NOP;
                        row_idx  <= '0;
                    end else begin
                        wait_cnt <= wait_cnt - WCW'(1);
                    end
                end
                PH_ISSUE: begin
                    row_idx <= row_idx + RW'(1);
                    if (row_idx == RW'(NROWS - 1)) begin
                        phase    <= PH_WAIT;
                        wait_cnt <= step_wait - WCW'(1);
                    end
                end
                PH_WAIT: begin
                    if (wait_cnt != '0) begin
                        wait_cnt <= wait_cnt - WCW'(1);
                    end else begin
                        phase   <= PH_ISSUE;
                        row_idx <= '0;
                        case (step_cmd)
                            CMD_NOP: step_cmd <= CMD_PRECHARGE;
                            CMD_PRECHARGE: begin
                                step_cmd <= CMD_REFRESH;
                                cbr_cnt  <= '0;
                            end
                            CMD_REFRESH: begin
                                if (cbr_cnt == CCW'(N_CBR - 1)) step_cmd <= CMD_MODESET;
                                else cbr_cnt <= cbr_cnt + CCW'(1);
                            end
                            default: phase <= PH_FINAL;
                        endcase
                    end
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

endmodule

// File: rtl/sdinit_chk.sv
// Property checker for the sequencer, attached to every instance by bind.
// Observes only the top-level ports.
module sdinit_chk #(
    parameter int NROWS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [2:0]       cmd_code,
    input logic [NROWS-1:0] cmd_cs,
    input logic [13:0]      cmd_addr,
    input logic             refresh_req
);

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_cs));

    // R6
    normal_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'b000) |-> (cmd_cs == '0));

    // R5
    addr_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_addr != '0) |-> (cmd_code == 3'b011 && cmd_cs != '0));

    // R7
    gap_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_cs == '0) |-> (cmd_code == 3'b001 || cmd_code == 3'b000));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10
    req_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> done);

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);

endmodule

bind sdram_init_seq sdinit_chk #(.NROWS(NROWS)) u_sdinit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .cmd_code    (cmd_code),
    .cmd_cs      (cmd_cs),
    .cmd_addr    (cmd_addr),
    .refresh_req (refresh_req)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NR    = 8;
    localparam int TPWR  = 20;
    localparam int TNOP  = 15;
    localparam int TRP   = 3;
    localparam int TRC   = 5;
    localparam int TMRD  = 2;
    localparam int NCBR  = 8;
    localparam int UNIT  = 4;
    localparam int RUNLEN = 180;

    // bit 64 = CAS latency 2, bits 63:0 = row boundaries (row 0 in LSB byte)
    localparam logic [64:0] VEC [5] = '{
        {1'b0, 64'h0807060504030201},
        {1'b1, 64'h0906060604040202},
        {1'b0, 64'h0000000000000000},
        {1'b1, 64'h1000000000000000},
        {1'b0, 64'h0808080804040404}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] row_bound = '0;
    logic        cas_lat2 = 1'b0;
    logic [2:0]  rate_code = 3'b000;
    logic [2:0]  cmd_code;
    logic [7:0]  cmd_cs;
    logic [13:0] cmd_addr;
    logic        busy, done, refresh_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    sdram_init_seq #(
        .NROWS(NR), .BW(8), .T_PWR(TPWR), .T_NOP(TNOP), .T_RP(TRP),
        .T_RC(TRC), .T_MRD(TMRD), .N_CBR(NCBR), .REF_UNIT(UNIT)
    ) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .row_bound(row_bound),
        .cas_lat2(cas_lat2), .rate_code(rate_code), .cmd_code(cmd_code),
        .cmd_cs(cmd_cs), .cmd_addr(cmd_addr), .busy(busy), .done(done),
        .refresh_req(refresh_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h exp %0h", tag, got, exp);
        end
    endtask

    // expected port values t cycles after the edge that sampled start
    task automatic expect_at(input int t, input logic [63:0] bnd, input bit cl2,
                             output int e_cmd, output int e_cs, output int e_addr,
                             output bit e_busy, output bit e_done);
        int base;
        int nsteps;
        base = TPWR;
        nsteps = 3 + NCBR;
        e_cmd = 1; e_cs = 0; e_addr = 0; e_busy = 1; e_done = 0;
        if (t < base) return;
        for (int s = 0; s < nsteps; s++) begin
            int c;
            int w;
            if (s == 0)               begin c = 1; w = TNOP; end
            else if (s == 1)          begin c = 2; w = TRP;  end
            else if (s < nsteps - 1)  begin c = 4; w = TRC;  end
            else                      begin c = 3; w = TMRD; end
            if (t < base + NR) begin
                int r;
                int prev;
                int cur;
                r = t - base;
                cur  = int'(bnd[8*r +: 8]);
                prev = (r == 0) ? 0 : int'(bnd[8*(r-1) +: 8]);
                if (cur > prev) begin
                    e_cmd = c;
                    e_cs = 1 << r;
                    if (c == 3)
                        e_addr = (r < 4) ? (cl2 ? 'h150 : 'h1D0) : (cl2 ? 'h1EA8 : 'h1E28);
                end
                return;
            end
            if (t < base + NR + w) return;
            base = base + NR + w;
        end
        e_cmd = 0;
        if (t > base) begin
            e_busy = 0;
            e_done = 1;
        end
    endtask

    // time from a rate change to the first request and to the next one
    task automatic measure(input logic [2:0] code, input int exp);
        int n;
        int m;
        rate_code = code;
        n = 0;
        do begin @(negedge clk); n++; end while (!refresh_req && n < 300);
        check(n == exp, $sformatf("R10 R11 first request code %0d", code), n, exp);
        m = 0;
        do begin @(negedge clk); m++; end while (!refresh_req && m < 300);
        check(m == exp, $sformatf("R10 interval code %0d", code), m, exp);
    endtask

    task automatic no_req(input logic [2:0] code, input int len);
        int hits;
        rate_code = code;
        hits = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (refresh_req) hits++;
        end
        check(hits == 0, $sformatf("R11 disabled code %0d requests", code), hits, 0);
    endtask

    initial begin
        int e_cmd, e_cs, e_addr;
        bit e_busy, e_done;
        int vbad;

        repeat (3) @(negedge clk);
        // reset state (R6, R9)
        check(cmd_code == 3'b000 && cmd_cs == 0 && cmd_addr == 0,
              "R6 reset port idle", {cmd_code, cmd_cs}, 0);
        check(!busy && !done && !refresh_req, "R9 reset flags",
              {busy, done, refresh_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && cmd_code == 3'b000, "R6 idle after reset", {busy, cmd_code}, 0);

        // table walk: full trace per boundary pattern
        for (int v = 0; v < 5; v++) begin
            row_bound = VEC[v][63:0];
            cas_lat2  = VEC[v][64];
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            vbad = 0;
            for (int t = 0; t < RUNLEN; t++) begin
                expect_at(t, VEC[v][63:0], VEC[v][64], e_cmd, e_cs, e_addr, e_busy, e_done);
                total++;
                if (int'(cmd_code) != e_cmd || int'(cmd_cs) != e_cs ||
                    int'(cmd_addr) != e_addr || busy != e_busy || done != e_done ||
                    (refresh_req && !e_done)) begin
                    bad++;
                    vbad++;
                    if (vbad < 5)
                        $display("FAIL R1 R2 R3 R4 R5 R7 R8 R9 vec %0d t %0d: got cmd %0h cs %0h addr %0h busy %0d done %0d exp cmd %0h cs %0h addr %0h busy %0d done %0d",
                                 v, t, cmd_code, cmd_cs, cmd_addr, busy, done,
                                 e_cmd, e_cs, e_addr, e_busy, e_done);
                end
                // R8: extra start in the middle of the sequence
                start = (t == 50);
                @(negedge clk);
            end
            start = 1'b0;
        end

        // refresh intervals and restart (R10, R11)
        no_req(3'b000, 100);
        measure(3'b010, UNIT);
        measure(3'b001, UNIT * 2);
        measure(3'b011, UNIT * 4);
        measure(3'b100, UNIT * 8);
        measure(3'b101, UNIT * 16);
        rate_code = 3'b101;
        repeat (30) @(negedge clk);
        measure(3'b010, UNIT);
        no_req(3'b110, 100);
        no_req(3'b111, 100);

        // R9: start while done restarts the sequence
        rate_code = 3'b010;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done && cmd_code == 3'b001, "R9 restart from done",
              {busy, done, cmd_code}, 5'b10001);
        begin
            int hits = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (refresh_req) hits++;
            end
            check(hits == 0, "R10 no request while busy", hits, 0);
        end
        begin
            int n = 0;
            while (!done && n < 400) begin @(negedge clk); n++; end
            check(done, "R9 done after restart", done, 1);
        end
        summary();
    end

endmodule